// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block decides which 5-bit frequency code a clock synthesizer runs from. When the power-good input rises, it captures five frequency-select straps, a current-mode strap and a watchdog-enable strap. After that rising edge it treats a shared board pin as an active-low power-down request. The active code is either the latched strap value or a software value held in the frequency-select register, and a software enable bit picks between them. Any change to the active code is marked by a one-clock update strobe, so downstream logic can perform a smooth transition.

The block also holds the output-enable masks, the spread-spectrum enable, a stepless-mode flag that hands frequency control to M/N programming, and a 3-bit ratio select. The ratio select is decoded into VCO divide ratios for the CPU, mid-rate (66 MHz class) and PCI clocks. A watchdog timeout pulse restores a known code. Depending on a safe-frequency enable, it either loads a stored safe code as the software code or falls back to the latched straps. The timeout also clears stepless mode. Registers are written through a single-cycle write strobe and read through a combinational read port.

Top module: `fsel_ctrl`

## Requirements
- R1: After reset, the outputs and registers hold these values:
  - `active_code`, `code_upd`, `power_down`, `spread_en`, `stepless_en` and `ratio_err` are 0.
  - All clock enables are 1.
  - The dividers are 2/4/8.
  - The latched straps read as zero: address 1 reads 0xE0 and address 2 reads 0x7F.
- R2: On the first clock edge that sees `pwr_good` high after it was low, the block latches `fs_strap`, `cur_strap` and `wd_strap`. If software select is off, `active_code` takes the strap value at that same edge. The latched straps read back as follows:
  - `fs_strap` in bits 4:0 of address 1.
  - `cur_strap` in bit 7 of address 2.
  - `wd_strap` in bit 6 of address 5.
- R3: A strap change while `pwr_good` stays high has no effect on the latched values or on `active_code`.
- R4: `power_down` equals the inverse of `pd_pin_n` once a `pwr_good` rising edge has been seen. Before that edge it is 0 whatever the pin does.
- R5: Address 0 is the frequency-select register.
  - Bit 1 is the software enable. When it is 1, `active_code` equals bits 6:2. When it is 0, `active_code` equals the latched straps.
  - The result takes effect at the write edge.
- R6: Bit 7 of address 0 drives `spread_en`.
- R7: `code_upd` is high for exactly the one cycle after an edge at which `active_code` changed. It stays low when a write leaves the code unchanged.
- R8: Bits 5:3 of address 10 select the cpu/mid/pci dividers as follows:
  - 0 gives 2/4/8.
  - 1 gives 2/5/10.
  - 2 gives 2/6/12.
  - 3 gives 3/6/12.
  - 4 gives 4/4/8.
  - 5 gives 4/6/12.
  - 6 gives 6/6/12.
- R9: Ratio code 7 leaves the dividers at their previous values and sets `ratio_err`. `ratio_err` stays set until a valid code is written.
- R10: Bit 7 of address 10 drives `stepless_en`.
- R11: A `wd_timeout` pulse clears `stepless_en`. What happens to the active code depends on the safe-frequency enable (bit 0 of address 0):
  - If that bit is 1, the safe code (bits 4:0 of address 5) becomes the software code and software select turns on.
  - If that bit is 0, software select turns off, so the latched straps drive `active_code`.
- R12: The clock-enable bits are writable, and their reset value is 1.
  - Bits 7:5 of address 1 drive `cpu_clk_en`.
  - Bits 6:0 of address 2 drive `pci_clk_en`.
  - The strap readback bits in these registers are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Power-good level; its rising edge latches the straps |
| fs_strap | input | 5 | Frequency-select straps |
| cur_strap | input | 1 | Current-mode strap |
| wd_strap | input | 1 | Watchdog-enable strap |
| pd_pin_n | input | 1 | Shared pin, an active-low power-down request after arming |
| wd_timeout | input | 1 | Watchdog timeout pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write address |
| reg_wdata | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| active_code | output | 5 | Active frequency code |
| code_upd | output | 1 | One-cycle strobe on an active code change |
| spread_en | output | 1 | Spread-spectrum enable |
| stepless_en | output | 1 | M/N programming mode |
| cpu_div | output | 4 | VCO to CPU divide ratio |
| mid_div | output | 4 | VCO to mid-rate clock divide ratio |
| pci_div | output | 4 | VCO to PCI divide ratio |
| ratio_err | output | 1 | The stored ratio code is invalid |
| power_down | output | 1 | Power-down request |
| cpu_clk_en | output | 3 | CPU clock enables |
| pci_clk_en | output | 7 | PCI clock enables |

## Verification
Every registered result is due at the first rising edge after its cause:
- A strap latch, a register write or a timeout changes `active_code`, the dividers, the flags and the enables at that edge.
- `code_upd` is high only in the cycle that follows that edge.

The bench drives each stimulus at a falling edge and samples at the next falling edge, then samples once more to confirm that the strobe has dropped. `rd_data` and `power_down` are combinational, so they are checked 1 ns after the address or pin changes.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int DIV_W = 4;

    typedef struct packed {
        logic [DIV_W-1:0] cpu;
        logic [DIV_W-1:0] mid;
        logic [DIV_W-1:0] pci;
    } ratio_t;

    typedef struct packed {
        logic   ok;
        ratio_t r;
    } ratio_res_t;

    localparam ratio_t RATIO_RST = '{cpu: 4'd2, mid: 4'd4, pci: 4'd8};

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
    parameter int FS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_good,
    input  logic [FS_W-1:0] fs_strap,
    input  logic            cur_strap,
    input  logic            wd_strap,
    input  logic            pd_pin_n,
    output logic [FS_W-1:0] fs_lat,
    output logic [FS_W-1:0] fs_nxt,
    output logic            cur_lat,
    output logic            wd_lat,
    output logic            armed,
    output logic            pg_rise,
    output logic            power_down
);

    typedef struct packed {
        logic            pg;
        logic            armed;
        logic [FS_W-1:0] fs;
        logic            cur;
        logic            wd;
    } st_t;

    st_t s_d, s_q;

    assign pg_rise = pwr_good & ~s_q.pg;

    always_comb begin
        s_d    = s_q;
        s_d.pg = pwr_good;
        if (pg_rise) begin
            s_d.armed = 1'b1;
            s_d.fs    = fs_strap;
            s_d.cur   = cur_strap;
            s_d.wd    = wd_strap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fs_lat     = s_q.fs;
    assign fs_nxt     = s_d.fs;
    assign cur_lat    = s_q.cur;
    assign wd_lat     = s_q.wd;
    assign armed      = s_q.armed;
    assign power_down = s_q.armed & ~pd_pin_n;

endmodule

// File: rtl/fsel_ratio_decode.sv
module fsel_ratio_decode
    import fsel_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    output ratio_res_t       res
);

    always_comb begin
        res    = '0;
        res.ok = 1'b1;
        case (sel)
            3'd0:    res.r = '{cpu: 4'd2, mid: 4'd4, pci: 4'd8};
            3'd1:    res.r = '{cpu: 4'd2, mid: 4'd5, pci: 4'd10};
            3'd2:    res.r = '{cpu: 4'd2, mid: 4'd6, pci: 4'd12};
            3'd3:    res.r = '{cpu: 4'd3, mid: 4'd6, pci: 4'd12};
            3'd4:    res.r = '{cpu: 4'd4, mid: 4'd4, pci: 4'd8};
            3'd5:    res.r = '{cpu: 4'd4, mid: 4'd6, pci: 4'd12};
            3'd6:    res.r = '{cpu: 4'd6, mid: 4'd6, pci: 4'd12};
            default: res.ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
    import fsel_pkg::*;
#(
    parameter int CODE_W  = 5,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int NUM_CPU = 3,
    parameter int NUM_PCI = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic [CODE_W-1:0]  fs_strap,
    input  logic               cur_strap,
    input  logic               wd_strap,
    input  logic               pd_pin_n,
    input  logic               wd_timeout,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [CODE_W-1:0]  active_code,
    output logic               code_upd,
    output logic               spread_en,
    output logic               stepless_en,
    output logic [DIV_W-1:0]   cpu_div,
    output logic [DIV_W-1:0]   mid_div,
    output logic [DIV_W-1:0]   pci_div,
    output logic               ratio_err,
    output logic               power_down,
    output logic [NUM_CPU-1:0] cpu_clk_en,
    output logic [NUM_PCI-1:0] pci_clk_en
);

    localparam int SEL_W     = 3;
    localparam int MSB       = DATA_W - 1;
    localparam int SW_LSB    = 2;
    localparam int SWEN_BIT  = 1;
    localparam int SAFE_BIT  = 0;
    localparam int WDL_BIT   = 6;
    localparam int RSEL_LSB  = 3;
    localparam logic [ADDR_W-1:0] A_FSEL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CPU  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PCI  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_WDOG = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(10);

    typedef struct packed {
        logic [CODE_W-1:0]  active;
        logic               upd;
        logic [CODE_W-1:0]  sw_code;
        logic               sw_en;
        logic               safe_en;
        logic               spread;
        logic [CODE_W-1:0]  safe_code;
        logic               stepless;
        logic [SEL_W-1:0]   rsel;
        logic               err;
        ratio_t             ratio;
        logic [NUM_CPU-1:0] cpu_en;
        logic [NUM_PCI-1:0] pci_en;
    } st_t;

    st_t s_d, s_q;

    logic [CODE_W-1:0] fs_lat, fs_nxt;
    logic              cur_lat, wd_lat, armed, pg_rise;
    ratio_res_t        wr_ratio;

    fsel_strap_latch #(.FS_W(CODE_W)) u_straps (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .fs_strap   (fs_strap),
        .cur_strap  (cur_strap),
        .wd_strap   (wd_strap),
        .pd_pin_n   (pd_pin_n),
        .fs_lat     (fs_lat),
        .fs_nxt     (fs_nxt),
        .cur_lat    (cur_lat),
        .wd_lat     (wd_lat),
        .armed      (armed),
        .pg_rise    (pg_rise),
        .power_down (power_down)
    );

    fsel_ratio_decode #(.SEL_W(SEL_W)) u_ratio (
        .sel (reg_wdata[RSEL_LSB +: SEL_W]),
        .res (wr_ratio)
    );

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            case (reg_addr)
                A_FSEL: begin
                    s_d.spread  = reg_wdata[MSB];
                    s_d.sw_code = reg_wdata[SW_LSB +: CODE_W];
                    s_d.sw_en   = reg_wdata[SWEN_BIT];
                    s_d.safe_en = reg_wdata[SAFE_BIT];
                end
                A_CPU:  s_d.cpu_en    = reg_wdata[MSB -: NUM_CPU];
                A_PCI:  s_d.pci_en    = reg_wdata[0 +: NUM_PCI];
                A_WDOG: s_d.safe_code = reg_wdata[0 +: CODE_W];
                A_DIV: begin
                    s_d.stepless = reg_wdata[MSB];
                    s_d.rsel     = reg_wdata[RSEL_LSB +: SEL_W];
                    if (wr_ratio.ok) s_d.ratio = wr_ratio.r;
                end
                default: ;
            endcase
        end
        if (wd_timeout) begin
            s_d.stepless = 1'b0;
            if (s_d.safe_en) begin
                s_d.sw_code = s_d.safe_code;
                s_d.sw_en   = 1'b1;
            end else begin
                s_d.sw_en   = 1'b0;
            end
        end
        s_d.err    = &s_d.rsel;
        s_d.active = s_d.sw_en ? s_d.sw_code : fs_nxt;
        s_d.upd    = (s_d.active != s_q.active);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.ratio  <= RATIO_RST;
            s_q.cpu_en <= '1;
            s_q.pci_en <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_FSEL: begin
                rd_data[MSB]                = s_q.spread;
                rd_data[SW_LSB +: CODE_W]   = s_q.sw_code;
                rd_data[SWEN_BIT]           = s_q.sw_en;
                rd_data[SAFE_BIT]           = s_q.safe_en;
            end
            A_CPU: begin
                rd_data[MSB -: NUM_CPU]     = s_q.cpu_en;
                rd_data[0 +: CODE_W]        = fs_lat;
            end
            A_PCI: begin
                rd_data[MSB]                = cur_lat;
                rd_data[0 +: NUM_PCI]       = s_q.pci_en;
            end
            A_WDOG: begin
                rd_data[WDL_BIT]            = wd_lat;
                rd_data[0 +: CODE_W]        = s_q.safe_code;
            end
            A_DIV: begin
                rd_data[MSB]                = s_q.stepless;
                rd_data[RSEL_LSB +: SEL_W]  = s_q.rsel;
            end
            default: ;
        endcase
    end

    assign active_code = s_q.active;
    assign code_upd    = s_q.upd;
    assign spread_en   = s_q.spread;
    assign stepless_en = s_q.stepless;
    assign cpu_div     = s_q.ratio.cpu;
    assign mid_div     = s_q.ratio.mid;
    assign pci_div     = s_q.ratio.pci;
    assign ratio_err   = s_q.err;
    assign cpu_clk_en  = s_q.cpu_en;
    assign pci_clk_en  = s_q.pci_en;

endmodule

// File: rtl/fsel_ctrl_chk.sv
module fsel_ctrl_chk #(
    parameter int CODE_W = 5,
    parameter int DIV_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] active_code,
    input logic              code_upd,
    input logic [DIV_W-1:0]  cpu_div,
    input logic [DIV_W-1:0]  mid_div,
    input logic [DIV_W-1:0]  pci_div,
    input logic              ratio_err,
    input logic              wd_timeout,
    input logic              stepless_en,
    input logic              armed,
    input logic              power_down,
    input logic              pg_rise,
    input logic [CODE_W-1:0] fs_lat
);

    AST_UPD_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd |-> (active_code != $past(active_code))); // R7

    AST_QUIET_WHEN_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        !code_upd |-> $stable(active_code)); // R7

    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_div == 4'd2 || cpu_div == 4'd3 || cpu_div == 4'd4 || cpu_div == 4'd6)); // R8

    AST_ERR_HOLDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_err |-> $stable({cpu_div, mid_div, pci_div})); // R9

    AST_WD_CLEARS_STEPLESS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wd_timeout) |-> !stepless_en); // R11

    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed); // R4

    AST_PD_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> armed); // R4

    AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_rise |=> $stable(fs_lat)); // R3

endmodule

bind fsel_ctrl fsel_ctrl_chk #(.CODE_W(CODE_W), .DIV_W(fsel_pkg::DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_code (active_code),
    .code_upd    (code_upd),
    .cpu_div     (cpu_div),
    .mid_div     (mid_div),
    .pci_div     (pci_div),
    .ratio_err   (ratio_err),
    .wd_timeout  (wd_timeout),
    .stepless_en (stepless_en),
    .armed       (armed),
    .power_down  (power_down),
    .pg_rise     (pg_rise),
    .fs_lat      (fs_lat)
);

// File: tb/fsel_ctrl_tb.sv
`timescale 1ns/1ps
module fsel_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic [4:0] fs_strap = 5'd0;
    logic       cur_strap = 1'b0;
    logic       wd_strap = 1'b0;
    logic       pd_pin_n = 1'b1;
    logic       wd_timeout = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;
    logic [4:0] active_code;
    logic       code_upd, spread_en, stepless_en, ratio_err, power_down;
    logic [3:0] cpu_div, mid_div, pci_div;
    logic [2:0] cpu_clk_en;
    logic [6:0] pci_clk_en;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fsel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .fs_strap(fs_strap),
        .cur_strap(cur_strap), .wd_strap(wd_strap), .pd_pin_n(pd_pin_n),
        .wd_timeout(wd_timeout), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .active_code(active_code), .code_upd(code_upd), .spread_en(spread_en),
        .stepless_en(stepless_en), .cpu_div(cpu_div), .mid_div(mid_div),
        .pci_div(pci_div), .ratio_err(ratio_err), .power_down(power_down),
        .cpu_clk_en(cpu_clk_en), .pci_clk_en(pci_clk_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [11:0] exp_ratio(input int c);
        case (c)
            0: return 12'h248;
            1: return 12'h25A;
            2: return 12'h26C;
            3: return 12'h36C;
            4: return 12'h448;
            5: return 12'h46C;
            default: return 12'h66C;
        endcase
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        chk("R1", "active_code", active_code, 0);
        chk("R1", "code_upd", code_upd, 0);
        chk("R1", "spread/stepless/err", {spread_en, stepless_en, ratio_err}, 0);
        chk("R1", "dividers", {cpu_div, mid_div, pci_div}, 12'h248);
        chk("R1", "enables", {cpu_clk_en, pci_clk_en}, 10'h3FF);
        rd(4'd1, d); chk("R1", "cpu reg", d, 8'hE0);
        rd(4'd2, d); chk("R1", "pci reg", d, 8'h7F);
        pd_pin_n = 1'b0; #1;
        chk("R4", "power_down before arm", power_down, 0);
        pd_pin_n = 1'b1;
    endtask

    task automatic t_strap_latch();
        logic [7:0] d;
        @(negedge clk);
        fs_strap = 5'h16; cur_strap = 1'b1; wd_strap = 1'b1;
        pwr_good = 1'b1;
        @(negedge clk);
        chk("R2", "active after pg rise", active_code, 5'h16);
        chk("R7", "upd after latch", code_upd, 1);
        rd(4'd1, d); chk("R2", "fs readback", d[4:0], 5'h16);
        rd(4'd2, d); chk("R2", "cur readback", d[7], 1);
        rd(4'd5, d); chk("R2", "wd readback", d[6], 1);
        @(negedge clk);
        chk("R7", "upd drops", code_upd, 0);
        fs_strap = 5'h09; cur_strap = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3", "active after strap change", active_code, 5'h16);
        rd(4'd1, d); chk("R3", "fs readback held", d[4:0], 5'h16);
        pd_pin_n = 1'b0; #1;
        chk("R4", "power_down armed low", power_down, 1);
        pd_pin_n = 1'b1; #1;
        chk("R4", "power_down armed high", power_down, 0);
    endtask

    task automatic t_sw_select();
        logic [7:0] d;
        wr(4'd0, 8'h8E);
        chk("R5", "sw code", active_code, 5'h03);
        chk("R6", "spread on", spread_en, 1);
        chk("R7", "upd on sw change", code_upd, 1);
        wr(4'd0, 8'h8E);
        chk("R7", "no upd same code", code_upd, 0);
        wr(4'd0, 8'h0C);
        chk("R5", "back to straps", active_code, 5'h16);
        chk("R6", "spread off", spread_en, 0);
        wr(4'd1, 8'h00);
        chk("R12", "cpu enables off", cpu_clk_en, 0);
        rd(4'd1, d); chk("R12", "strap bits read-only", d[4:0], 5'h16);
        wr(4'd2, 8'h05);
        chk("R12", "pci enables", pci_clk_en, 7'h05);
        rd(4'd2, d); chk("R12", "cur bit read-only", d[7], 1);
        wr(4'd1, 8'hE0);
        wr(4'd2, 8'h7F);
    endtask

    task automatic t_ratio();
        for (int c = 0; c < 7; c++) begin
            wr(4'd10, 8'(c << 3));
            chk("R8", $sformatf("ratio code %0d", c), {cpu_div, mid_div, pci_div}, exp_ratio(c));
            chk("R8", "no err", ratio_err, 0);
        end
        wr(4'd10, 8'h38);
        chk("R9", "hold on 111", {cpu_div, mid_div, pci_div}, 12'h66C);
        chk("R9", "err set", ratio_err, 1);
        wr(4'd10, 8'h08);
        chk("R9", "recover", {cpu_div, mid_div, pci_div}, 12'h25A);
        chk("R9", "err clear", ratio_err, 0);
        wr(4'd10, 8'h88);
        chk("R10", "stepless on", stepless_en, 1);
    endtask

    task automatic t_watchdog();
        wr(4'd5, 8'h0B);
        wr(4'd0, 8'h01);
        chk("R11", "straps before timeout", active_code, 5'h16);
        @(negedge clk); wd_timeout = 1'b1;
        @(negedge clk); wd_timeout = 1'b0;
        chk("R11", "safe code loaded", active_code, 5'h0B);
        chk("R11", "stepless cleared", stepless_en, 0);
        chk("R7", "upd on timeout", code_upd, 1);
        wr(4'd0, 8'h12);
        chk("R5", "sw code 4", active_code, 5'h04);
        @(negedge clk); wd_timeout = 1'b1;
        @(negedge clk); wd_timeout = 1'b0;
        chk("R11", "fallback to straps", active_code, 5'h16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strap_latch();
        t_sw_select();
        t_ratio();
        t_watchdog();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule